// File: doc/BRIEF.md
# UART Interrupt Flag and Enable Unit

This block holds the interrupt status of a UART. It takes single-cycle event pulses from the receiver: parity error, framing error, BREAK frame received, end of a BREAK run, and receive frame timeout. It also watches the live TX and RX FIFO occupancy counts against two programmable threshold levels.

Every source has a sticky flag in a flag register that software clears by writing one, and a matching bit in an enable register. The registered OR of all enabled flags drives a single interrupt line. A two-address register port gives access to both registers. A small two-state machine tracks runs of consecutive BREAK frames, so that the first frame and the end of the run are reported as separate flags. The threshold flags are level-conditioned, so a clear only holds if software also removes the condition.

Register layout (both registers): bit 0 parity error, bit 1 framing error, bit 2 first BREAK, bit 3 last BREAK, bit 4 frame timeout, bit 5 TX threshold, bit 6 TX almost empty, bit 7 RX threshold. Bits above 7 are reserved. Address 0 selects flags and address 1 selects enables. Break tracker states: `BRK_IDLE` (no run in progress) and `BRK_RUN` (inside a BREAK run). Transitions: `BRK_IDLE`→`BRK_RUN` on a BREAK frame without end-of-run. `BRK_RUN`→`BRK_IDLE` on end-of-run. All other cases stay in place.

Top module: `uirq_top`

## Requirements
- R1: Writing 1 to a flag bit at address 0 clears that flag. Writing 0 leaves it unchanged, and flags stay set until cleared.
- R2: If a set pulse for an event flag (bits 0-4, 6) and a write-one-to-clear of the same bit arrive in the same cycle, the flag ends up set.
- R3: The TX threshold flag (bit 5) sets at the clock edge where tx count <= tx level holds. After a clear it reads 0 for one cycle and then sets again if the condition still holds.
- R4: The RX threshold flag (bit 7) behaves the same way as R3, with the condition rx count >= rx level.
- R5: The TX almost-empty flag (bit 6) sets at the edge where the TX count enters the value 1 from any other value. It does not set again while the count stays at 1.
- R6: In `BRK_IDLE`, a BREAK frame pulse sets the first-BREAK flag (bit 2). Further BREAK frames in `BRK_RUN` do not set it.
- R7: An end-of-run pulse in `BRK_RUN` sets the last-BREAK flag (bit 3) and returns to `BRK_IDLE`. An end-of-run pulse in `BRK_IDLE` alone is ignored. A BREAK frame together with end-of-run in `BRK_IDLE` sets bits 2 and 3 and stays in `BRK_IDLE`.
- R8: The parity, framing and timeout pulses set bits 0, 1 and 4 at the next edge.
- R9: irq_o is high one cycle after any flag bit and its enable bit (address 1) are both 1. An enable of 0 blocks that source.
- R10: Reserved bits (above bit 7) of both registers read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| par_err_i | input | 1 | Parity error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| brk_frame_i | input | 1 | BREAK frame received pulse |
| brk_done_i | input | 1 | BREAK run ended pulse |
| rx_tmo_i | input | 1 | Receive frame timeout pulse |
| tx_cnt_i | input | CW | TX FIFO entry count |
| tx_lvl_i | input | CW | TX threshold level |
| rx_cnt_i | input | CW | RX FIFO entry count |
| rx_lvl_i | input | CW | RX threshold level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = flags, 1 = enables |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for the selected register |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the unit with a FIFO depth of 4, which gives 3-bit counts. At that size, every pairing of count and level from 0 to 4 can be swept for both threshold flags, including the clear-then-reassert cycle. A 16-bit register width leaves eight reserved bits to probe. All 32 enable masks over the five receiver sources are swept against a fixed flag pattern. The expected interrupt level is computed arithmetically for each mask.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NF = 8;

    localparam int B_PAR   = 0;
    localparam int B_FRM   = 1;
    localparam int B_BRK1  = 2;
    localparam int B_BRKN  = 3;
    localparam int B_TMO   = 4;
    localparam int B_TXTH  = 5;
    localparam int B_TXAE  = 6;
    localparam int B_RXTH  = 7;

    // Bits whose flag is re-evaluated from a live level rather than an event
    localparam logic [NF-1:0] LEVEL_BITS = NF'((1 << B_TXTH) | (1 << B_RXTH));

    typedef enum logic [0:0] {
        BRK_IDLE = 1'b0,
        BRK_RUN  = 1'b1
    } brk_state_e;

endpackage

// File: rtl/uirq_brk_fsm.sv
module uirq_brk_fsm
    import uirq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic brk_frame_i,
    input  logic brk_done_i,
    output logic first_set_o,
    output logic last_set_o
);

    brk_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= BRK_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        first_set_o = 1'b0;
        last_set_o  = 1'b0;
        unique case (state_q)
            BRK_IDLE: begin
                first_set_o = brk_frame_i;
                last_set_o  = brk_frame_i & brk_done_i;
                if (brk_frame_i && !brk_done_i) state_d = BRK_RUN;
            end
            BRK_RUN: begin
                last_set_o = brk_done_i;
                if (brk_done_i) state_d = BRK_IDLE;
            end
            default: state_d = BRK_IDLE;
        endcase
    end

    AST_BRK_ENTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == BRK_IDLE && brk_frame_i && !brk_done_i) |=> (state_q == BRK_RUN)); // R6
    AST_BRK_NO_FIRST_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == BRK_RUN) |-> !first_set_o); // R6
    AST_BRK_LAST_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_set_o |-> brk_done_i); // R7
    AST_BRK_EXIT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == BRK_RUN && brk_done_i) |=> (state_q == BRK_IDLE)); // R7

endmodule

// File: rtl/uirq_fifo_cond.sv
module uirq_fifo_cond #(
    parameter int CW = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] tx_cnt_i,
    input  logic [CW-1:0] tx_lvl_i,
    input  logic [CW-1:0] rx_cnt_i,
    input  logic [CW-1:0] rx_lvl_i,
    output logic          tx_thr_o,
    output logic          rx_thr_o,
    output logic          tx_ae_set_o
);

    logic tx_one;
    logic was_one_q;

    assign tx_one   = (tx_cnt_i == CW'(1));
    assign tx_thr_o = (tx_cnt_i <= tx_lvl_i);
    assign rx_thr_o = (rx_cnt_i >= rx_lvl_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) was_one_q <= 1'b0;
        else         was_one_q <= tx_one;
    end

    assign tx_ae_set_o = tx_one & ~was_one_q;

    AST_AE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_ae_set_o && tx_one) |=> !(tx_ae_set_o && $stable(tx_cnt_i))); // R5
    AST_AE_AT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_ae_set_o |-> (tx_cnt_i == CW'(1))); // R5

endmodule

// File: rtl/uirq_flag_bank.sv
module uirq_flag_bank
    import uirq_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] flag_o
);

    logic [NF-1:0] flag_q;

    for (genvar i = 0; i < NF; i++) begin : g_bit
        if (LEVEL_BITS[i]) begin : g_level
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni)       flag_q[i] <= 1'b0;
                else if (clr_i[i]) flag_q[i] <= 1'b0;
                else               flag_q[i] <= flag_q[i] | set_i[i];
            end
            AST_LVL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
                clr_i[i] |=> !flag_q[i]); // R3
            AST_LVL_REASSERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (set_i[i] && !clr_i[i]) |=> flag_q[i]); // R4
        end else begin : g_event
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) flag_q[i] <= 1'b0;
                else         flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_i[i]);
            end
            AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
                set_i[i] |=> flag_q[i]); // R2
            AST_W1C_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (clr_i[i] && !set_i[i]) |=> !flag_q[i]); // R1
        end
        AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]); // R1
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/uirq_top.sv
module uirq_top
    import uirq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          par_err_i,
    input  logic          frm_err_i,
    input  logic          brk_frame_i,
    input  logic          brk_done_i,
    input  logic          rx_tmo_i,
    input  logic [CW-1:0] tx_cnt_i,
    input  logic [CW-1:0] tx_lvl_i,
    input  logic [CW-1:0] rx_cnt_i,
    input  logic [CW-1:0] rx_lvl_i,
    input  logic          reg_wr_i,
    input  logic          reg_addr_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          irq_o
);

    logic          brk_first, brk_last;
    logic          tx_thr, rx_thr, tx_ae_set;
    logic [NF-1:0] set_vec, clr_vec, flags, en_q;
    logic          irq_q;
    logic          unused_rsv;

    uirq_brk_fsm u_brk (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .brk_frame_i (brk_frame_i),
        .brk_done_i  (brk_done_i),
        .first_set_o (brk_first),
        .last_set_o  (brk_last)
    );

    uirq_fifo_cond #(.CW(CW)) u_cond (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tx_cnt_i    (tx_cnt_i),
        .tx_lvl_i    (tx_lvl_i),
        .rx_cnt_i    (rx_cnt_i),
        .rx_lvl_i    (rx_lvl_i),
        .tx_thr_o    (tx_thr),
        .rx_thr_o    (rx_thr),
        .tx_ae_set_o (tx_ae_set)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[B_PAR]  = par_err_i;
        set_vec[B_FRM]  = frm_err_i;
        set_vec[B_BRK1] = brk_first;
        set_vec[B_BRKN] = brk_last;
        set_vec[B_TMO]  = rx_tmo_i;
        set_vec[B_TXTH] = tx_thr;
        set_vec[B_TXAE] = tx_ae_set;
        set_vec[B_RXTH] = rx_thr;
    end

    assign clr_vec = (reg_wr_i && !reg_addr_i) ? reg_wdata_i[NF-1:0] : '0;

    uirq_flag_bank u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_o (flags)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q  <= '0;
            irq_q <= 1'b0;
        end else begin
            if (reg_wr_i && reg_addr_i) en_q <= reg_wdata_i[NF-1:0];
            irq_q <= |(flags & en_q);
        end
    end

    assign irq_o       = irq_q;
    assign reg_rdata_o = DW'(reg_addr_i ? en_q : flags);
    assign unused_rsv  = ^reg_wdata_i[DW-1:NF];

    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(flags & en_q)) |=> irq_o); // R9
    AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|(flags & en_q)) |=> !irq_o); // R9
    AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[DW-1:NF] == '0); // R10

endmodule

// File: tb/tb_uirq_top.sv
module tb_uirq_top;
    localparam int DEPTH = 4;
    localparam int DW    = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          par = 0, frm = 0, brk = 0, done = 0, tmo = 0;
    logic [CW-1:0] tx_cnt = CW'(DEPTH), tx_lvl = '0, rx_cnt = '0, rx_lvl = CW'(DEPTH);
    logic          wr = 0, addr = 0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;
    int            checks = 0, errors = 0;
    bit            finished = 0;

    always #10 clk = ~clk;

    uirq_top #(.DEPTH(DEPTH), .DW(DW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .par_err_i(par), .frm_err_i(frm),
        .brk_frame_i(brk), .brk_done_i(done), .rx_tmo_i(tmo),
        .tx_cnt_i(tx_cnt), .tx_lvl_i(tx_lvl), .rx_cnt_i(rx_cnt), .rx_lvl_i(rx_lvl),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [DW-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wreg(input logic a, input logic [DW-1:0] d);
        wr = 1; addr = a; wdata = d;
        cyc();
        wr = 0; wdata = '0;
    endtask

    task automatic chk_bit(string req, int b, logic exp);
        logic [DW-1:0] v;
        rd(1'b0, v);
        check(req, 32'(v[b]), 32'(exp));
    endtask

    initial begin
        logic [DW-1:0] v;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // reset state
        rd(1'b0, v); check("reset flags", 32'(v), 0);
        rd(1'b1, v); check("reset enables", 32'(v), 0);
        check("reset irq", 32'(irq), 0);

        // R8: receiver error and timeout pulses
        par = 1; cyc(); par = 0; chk_bit("R8 parity", 0, 1);
        frm = 1; cyc(); frm = 0; chk_bit("R8 framing", 1, 1);
        tmo = 1; cyc(); tmo = 0; chk_bit("R8 timeout", 4, 1);

        // R1: write zero keeps, write one clears
        wreg(1'b0, '0);
        rd(1'b0, v); check("R1 write0 keeps", 32'(v[4:0]), 32'h13);
        wreg(1'b0, 16'h0001);
        rd(1'b0, v); check("R1 write1 clears bit0", 32'(v[4:0]), 32'h12);
        wreg(1'b0, 16'h0012);
        rd(1'b0, v); check("R1 cleared", 32'(v[4:0]), 0);

        // R2: set wins over simultaneous clear
        tmo = 1; wreg(1'b0, 16'h0010); tmo = 0;
        chk_bit("R2 set wins", 4, 1);
        wreg(1'b0, 16'h0010);

        // R6 / R7: break run tracking
        brk = 1; cyc(); brk = 0;
        rd(1'b0, v); check("R6 first break", 32'(v[3:2]), 32'h1);
        wreg(1'b0, 16'h0004);
        brk = 1; cyc(); cyc(); brk = 0;
        chk_bit("R6 no first inside run", 2, 0);
        done = 1; cyc(); done = 0;
        rd(1'b0, v); check("R7 last break", 32'(v[3:2]), 32'h2);
        wreg(1'b0, 16'h0008);
        done = 1; cyc(); done = 0;
        chk_bit("R7 done in idle ignored", 3, 0);
        brk = 1; done = 1; cyc(); brk = 0; done = 0;
        rd(1'b0, v); check("R7 single-frame run", 32'(v[3:2]), 32'h3);
        wreg(1'b0, 16'h000C);
        brk = 1; cyc(); brk = 0;
        chk_bit("R7 stayed idle", 2, 1);
        done = 1; cyc(); done = 0;
        wreg(1'b0, 16'h000C);

        // R5: almost-empty edge
        tx_cnt = 1; cyc();
        chk_bit("R5 enter one", 6, 1);
        wreg(1'b0, 16'h0040);
        cyc(); cyc();
        chk_bit("R5 no reset while held", 6, 0);
        tx_cnt = 2; cyc(); tx_cnt = 1; cyc();
        chk_bit("R5 reenter from two", 6, 1);
        wreg(1'b0, 16'h0040);
        tx_cnt = 0; cyc(); tx_cnt = 1; cyc();
        chk_bit("R5 reenter from zero", 6, 1);
        tx_cnt = CW'(DEPTH); wreg(1'b0, 16'h0060);

        // R3: TX threshold sweep
        for (int c = 0; c <= DEPTH; c++) begin
            for (int l = 0; l <= DEPTH; l++) begin
                tx_cnt = CW'(c); tx_lvl = CW'(l);
                wreg(1'b0, 16'h0020);
                chk_bit("R3 cleared", 5, 0);
                cyc();
                chk_bit("R3 level", 5, (c <= l));
            end
        end
        tx_cnt = CW'(DEPTH); tx_lvl = '0; wreg(1'b0, 16'h0060);

        // R4: RX threshold sweep
        for (int c = 0; c <= DEPTH; c++) begin
            for (int l = 0; l <= DEPTH; l++) begin
                rx_cnt = CW'(c); rx_lvl = CW'(l);
                wreg(1'b0, 16'h0080);
                chk_bit("R4 cleared", 7, 0);
                cyc();
                chk_bit("R4 level", 7, (c >= l));
            end
        end
        rx_cnt = '0; rx_lvl = CW'(DEPTH); wreg(1'b0, 16'h00C0);
        rd(1'b0, v); check("R4 all clear", 32'(v), 0);

        // R9: enable mask sweep over bits 0..4 with flags 0x1D
        par = 1; tmo = 1; brk = 1; done = 1; cyc();
        par = 0; tmo = 0; brk = 0; done = 0;
        rd(1'b0, v); check("R9 flag pattern", 32'(v), 32'h1D);
        for (int m = 0; m < 32; m++) begin
            wreg(1'b1, DW'(m));
            cyc();
            check("R9 irq mask", 32'(irq), 32'((m & 32'h1D) != 0));
        end

        // R10: reserved bits
        wreg(1'b1, 16'hFFFF);
        rd(1'b1, v); check("R10 enable reserved", 32'(v), 32'h00FF);
        par = 1; cyc(); par = 0;
        rd(1'b0, v); check("R10 flag reserved", 32'(v[DW-1:8]), 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule